// File: doc/BRIEF.md
# Bus Command Delay Sequencer

The block times the read and write command strobes of one bus cycle at a time. A cycle begins when the address goes onto the bus, which is marked by a one-clock `cyc_start` pulse. The command stays inactive for a delay that depends on the kind of cycle. The command then stays active until the cycle length, which the wait-state count sets, has run out. The delay moves only the leading edge of the command. The trailing edge stays where the wait states put it, so a longer delay gives a shorter command pulse and leaves the cycle length unchanged.

The block runs on a clock at twice the bus clock rate, so every count is in half bus-clock units (ticks). At the start pulse it latches the cycle attributes: memory or I/O, read or write, 8-bit or 16-bit, and target. It also latches the configuration bits that choose the delay and the chip-select mode. From that point a three-state machine runs the cycle. **IDLE** waits for a start. **IDLE→SETUP** is taken when the delay is non-zero, and **IDLE→ACTIVE** is taken when it is zero. **SETUP→ACTIVE** is taken when the tick count reaches the delay. **ACTIVE→IDLE** is taken on the last tick of the cycle.

Two ROM chip-selects, one for the BIOS region and one for the DOS region, go low for cycles aimed at their region. Each one is either gated by the command or driven as a plain address decode. A stopped-clock input forces both chip-selects high. All strobes and chip-selects are active-low register outputs.

Top module: `bus_cmd_seq`

## Requirements
- R1: After reset, all six outputs are high and the sequencer is idle.
- R2: The cycle length is L = BASE_HALF + 2*ws_count ticks (default BASE_HALF=4). The tick after the edge that samples `cyc_start` is tick 0. The command is high again from tick L, whatever the delay.
- R3: Memory delays in ticks are as follows. A 16-bit memory cycle has 0. An 8-bit cycle to target 00 (ISA) has 2 when `cfg_long_dly`=1 and 1 otherwise. An 8-bit cycle to target 01 (BIOS) has 1. For memory cycles, target 11 behaves like 00.
- R4: An 8-bit memory cycle to target 10 (DOS) has a delay of 0 when `cfg_dos_ws`=00. For any other value of `cfg_dos_ws`, it has 2 when `cfg_long_dly`=1 and 1 otherwise.
- R5: I/O delays in ticks are as follows. An 8-bit cycle to target 11 (internal) has 1. A 16-bit I/O cycle has 1. An 8-bit cycle to any other target (external) uses `cfg_io_dly`: 00 gives 1, 01 gives 2, and 10 or 11 gives 4.
- R6: When the delay D is at least L, it is clamped to L-1, so the command is active for at least one tick. Otherwise the command is low exactly on ticks D to L-1.
- R7: Only the strobe chosen by the latched attributes goes low. `cyc_is_io`=0 selects the memory strobes, and `cyc_is_wr`=1 selects the write strobe.
- R8: In gated mode (mode bit 0), a chip-select is low exactly while the command of a memory cycle to its target is low.
- R9: In decode mode (mode bit 1), a chip-select is low on ticks 0 to L-1 of a memory cycle to its target. `bios_cs_n` serves target 01 with `cfg_bios_dec`. `dos_cs_n` serves target 10 with `cfg_dos_dec`.
- R10: When `clk_stopped` is high at a clock edge, both chip-selects are high after that edge.
- R11: A `cyc_start` that arrives during a cycle is ignored. Inputs that change after the start have no effect on the cycle already running. Outputs stay high for at least one tick between cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Twice-rate clock; one period is one tick |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | One-tick pulse: address driven, cycle begins |
| cyc_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| cyc_is_wr | input | 1 | 1 = write, 0 = read |
| cyc_16bit | input | 1 | 1 = 16-bit cycle |
| cyc_tgt | input | 2 | Target: 00 ISA/external, 01 BIOS, 10 DOS, 11 internal I/O |
| ws_count | input | WS_W | Wait states, in bus clocks |
| cfg_long_dly | input | 1 | Selects the longer delay for ISA and DOS memory |
| cfg_io_dly | input | 2 | Delay field for 8-bit external I/O |
| cfg_dos_ws | input | 2 | DOS wait-state bits; 00 gives zero delay |
| cfg_bios_dec | input | 1 | 1 = BIOS chip-select is a plain decode |
| cfg_dos_dec | input | 1 | 1 = DOS chip-select is a plain decode |
| clk_stopped | input | 1 | CPU clock stopped; forces chip-selects high |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| bios_cs_n | output | 1 | BIOS ROM chip-select, active low |
| dos_cs_n | output | 1 | DOS ROM chip-select, active low |

## Verification
A wrong latched delay or a wrong state transition moves the falling edge of the command by whole ticks. That shift is visible at the port in the very cycle it happens. A wrong length count moves the rising edge, so it is also visible within one cycle. A corrupted attribute latch drives the wrong strobe, or the wrong chip-select, on the first active tick. A start accepted while busy restarts the count, which stretches the command window past tick L-1. For these reasons the outputs are compared against a tick-by-tick model of every cycle, from tick 0 through tick L.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACTIVE = 2'd2
    } seq_state_t;

    localparam logic [1:0] TGT_EXT  = 2'd0;
    localparam logic [1:0] TGT_BIOS = 2'd1;
    localparam logic [1:0] TGT_DOS  = 2'd2;
    localparam logic [1:0] TGT_INT  = 2'd3;

    typedef struct packed {
        logic       is_io;
        logic       is_wr;
        logic [1:0] tgt;
        logic       bios_dec;
        logic       dos_dec;
    } cyc_attr_t;

endpackage

// File: rtl/bcd_delay_sel.sv
module bcd_delay_sel
    import bcd_pkg::*;
#(
    parameter int WS_W      = 4,
    parameter int BASE_HALF = 4,
    parameter int LEN_W     = 6
) (
    input  logic             is_io,
    input  logic             is_16,
    input  logic [1:0]       tgt,
    input  logic             long_dly,
    input  logic [1:0]       io_dly,
    input  logic [1:0]       dos_ws,
    input  logic [WS_W-1:0]  ws_count,
    output logic [LEN_W-1:0] dly_half,
    output logic [LEN_W-1:0] len_half
);
    localparam int RAW_W = 3;

    logic [RAW_W-1:0] raw_dly;
    logic [RAW_W-1:0] isa_dly;

    assign isa_dly  = long_dly ? 3'd2 : 3'd1;
    assign len_half = LEN_W'(BASE_HALF) + (LEN_W'(ws_count) << 1);

    always_comb begin
        raw_dly = 3'd0;
        if (!is_io) begin
            if (is_16) begin
                raw_dly = 3'd0;
            end else begin
                unique case (tgt)
                    TGT_BIOS: raw_dly = 3'd1;
                    TGT_DOS:  raw_dly = (dos_ws == 2'b00) ? 3'd0 : isa_dly;
                    default:  raw_dly = isa_dly;
                endcase
            end
        end else begin
            if (is_16 || tgt == TGT_INT) begin
                raw_dly = 3'd1;
            end else begin
                unique case (io_dly)
                    2'b00:   raw_dly = 3'd1;
                    2'b01:   raw_dly = 3'd2;
                    default: raw_dly = 3'd4;
                endcase
            end
        end
    end

    always_comb begin
        if (LEN_W'(raw_dly) >= len_half) begin
            dly_half = len_half - LEN_W'(1);
        end else begin
            dly_half = LEN_W'(raw_dly);
        end
    end

endmodule

// File: rtl/bcd_seq_fsm.sv
module bcd_seq_fsm
    import bcd_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  cyc_attr_t        attr_in,
    input  logic [LEN_W-1:0] dly_in,
    input  logic [LEN_W-1:0] len_in,
    output seq_state_t       state_d,
    output cyc_attr_t        attr_d
);
    seq_state_t       state_q;
    cyc_attr_t        attr_q;
    logic [LEN_W-1:0] tick_q, tick_d;
    logic [LEN_W-1:0] dly_q, dly_d;
    logic [LEN_W-1:0] len_q, len_d;
    logic [LEN_W-1:0] tick_inc;

    assign tick_inc = tick_q + LEN_W'(1);

    always_comb begin
        state_d = state_q;
        attr_d  = attr_q;
        tick_d  = tick_q;
        dly_d   = dly_q;
        len_d   = len_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cyc_start) begin
                    attr_d  = attr_in;
                    dly_d   = dly_in;
                    len_d   = len_in;
                    tick_d  = '0;
                    state_d = (dly_in == '0) ? ST_ACTIVE : ST_SETUP;
                end
            end
            ST_SETUP: begin
                tick_d = tick_inc;
                if (tick_inc == dly_q) begin
                    state_d = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (tick_inc == len_q) begin
                    state_d = ST_IDLE;
                end else begin
                    tick_d = tick_inc;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            attr_q  <= '0;
            tick_q  <= '0;
            dly_q   <= '0;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            attr_q  <= attr_d;
            tick_q  <= tick_d;
            dly_q   <= dly_d;
            len_q   <= len_d;
        end
    end

    assert_end_at_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && state_d == ST_IDLE) |-> (tick_q == len_q - LEN_W'(1)));

    assert_setup_leaves_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP) |-> (tick_q < len_q - LEN_W'(1)));

    assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && cyc_start) |=> $stable(attr_q));

endmodule

// File: rtl/bcd_strobe_out.sv
module bcd_strobe_out
    import bcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t state_d,
    input  cyc_attr_t  attr_d,
    input  logic       clk_stopped,
    output logic       mem_rd_n,
    output logic       mem_wr_n,
    output logic       io_rd_n,
    output logic       io_wr_n,
    output logic       bios_cs_n,
    output logic       dos_cs_n
);
    logic cmd_on, in_cyc, mem_cyc;
    logic bios_on, dos_on;
    logic bios_dec_q;

    assign cmd_on  = (state_d == ST_ACTIVE);
    assign in_cyc  = (state_d != ST_IDLE);
    assign mem_cyc = in_cyc && !attr_d.is_io;
    assign bios_on = mem_cyc && (attr_d.tgt == TGT_BIOS) && (attr_d.bios_dec || cmd_on) && !clk_stopped;
    assign dos_on  = mem_cyc && (attr_d.tgt == TGT_DOS) && (attr_d.dos_dec || cmd_on) && !clk_stopped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_rd_n   <= 1'b1;
            mem_wr_n   <= 1'b1;
            io_rd_n    <= 1'b1;
            io_wr_n    <= 1'b1;
            bios_cs_n  <= 1'b1;
            dos_cs_n   <= 1'b1;
            bios_dec_q <= 1'b0;
        end else begin
            mem_rd_n   <= !(cmd_on && !attr_d.is_io && !attr_d.is_wr);
            mem_wr_n   <= !(cmd_on && !attr_d.is_io &&  attr_d.is_wr);
            io_rd_n    <= !(cmd_on &&  attr_d.is_io && !attr_d.is_wr);
            io_wr_n    <= !(cmd_on &&  attr_d.is_io &&  attr_d.is_wr);
            bios_cs_n  <= !bios_on;
            dos_cs_n   <= !dos_on;
            bios_dec_q <= attr_d.bios_dec;
        end
    end

    assert_single_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~{mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}));

    assert_stop_forces_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stopped |=> (bios_cs_n && dos_cs_n));

    assert_gated_cs_needs_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bios_cs_n && !bios_dec_q) |-> (!mem_rd_n || !mem_wr_n));

    assert_cs_not_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bios_cs_n && !dos_cs_n));

endmodule

// File: rtl/bus_cmd_seq.sv
module bus_cmd_seq
    import bcd_pkg::*;
#(
    parameter int WS_W      = 4,
    parameter int BASE_HALF = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc_start,
    input  logic            cyc_is_io,
    input  logic            cyc_is_wr,
    input  logic            cyc_16bit,
    input  logic [1:0]      cyc_tgt,
    input  logic [WS_W-1:0] ws_count,
    input  logic            cfg_long_dly,
    input  logic [1:0]      cfg_io_dly,
    input  logic [1:0]      cfg_dos_ws,
    input  logic            cfg_bios_dec,
    input  logic            cfg_dos_dec,
    input  logic            clk_stopped,
    output logic            mem_rd_n,
    output logic            mem_wr_n,
    output logic            io_rd_n,
    output logic            io_wr_n,
    output logic            bios_cs_n,
    output logic            dos_cs_n
);
    localparam int MAX_LEN = BASE_HALF + 2 * ((1 << WS_W) - 1);
    localparam int LEN_W   = $clog2(MAX_LEN + 1);

    logic [LEN_W-1:0] dly_half, len_half;
    cyc_attr_t        attr_in, attr_d;
    seq_state_t       state_d;

    assign attr_in = '{is_io: cyc_is_io, is_wr: cyc_is_wr, tgt: cyc_tgt,
                       bios_dec: cfg_bios_dec, dos_dec: cfg_dos_dec};

    bcd_delay_sel #(.WS_W(WS_W), .BASE_HALF(BASE_HALF), .LEN_W(LEN_W)) u_dly (
        .is_io(cyc_is_io), .is_16(cyc_16bit), .tgt(cyc_tgt),
        .long_dly(cfg_long_dly), .io_dly(cfg_io_dly), .dos_ws(cfg_dos_ws),
        .ws_count(ws_count), .dly_half(dly_half), .len_half(len_half)
    );

    bcd_seq_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .attr_in(attr_in),
        .dly_in(dly_half), .len_in(len_half), .state_d(state_d), .attr_d(attr_d)
    );

    bcd_strobe_out u_out (
        .clk(clk), .rst_n(rst_n), .state_d(state_d), .attr_d(attr_d),
        .clk_stopped(clk_stopped),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
        .bios_cs_n(bios_cs_n), .dos_cs_n(dos_cs_n)
    );

endmodule

// File: tb/bus_cmd_seq_bench.sv
module bus_cmd_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WS_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_start = 1'b0, cyc_is_io = 1'b0, cyc_is_wr = 1'b0, cyc_16bit = 1'b0;
    logic [1:0] cyc_tgt = 2'd0;
    logic [WS_W-1:0] ws_count = '0;
    logic cfg_long_dly = 1'b0;
    logic [1:0] cfg_io_dly = 2'd0, cfg_dos_ws = 2'd0;
    logic cfg_bios_dec = 1'b0, cfg_dos_dec = 1'b0, clk_stopped = 1'b0;
    logic mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, bios_cs_n, dos_cs_n;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cmd_seq #(.WS_W(WS_W), .BASE_HALF(4)) u_bus_cmd_seq (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_is_io(cyc_is_io),
        .cyc_is_wr(cyc_is_wr), .cyc_16bit(cyc_16bit), .cyc_tgt(cyc_tgt),
        .ws_count(ws_count), .cfg_long_dly(cfg_long_dly), .cfg_io_dly(cfg_io_dly),
        .cfg_dos_ws(cfg_dos_ws), .cfg_bios_dec(cfg_bios_dec), .cfg_dos_dec(cfg_dos_dec),
        .clk_stopped(clk_stopped), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .bios_cs_n(bios_cs_n), .dos_cs_n(dos_cs_n)
    );

    function automatic int model_len(int ws);
        return 4 + 2 * ws;
    endfunction

    function automatic int model_dly(logic io, logic b16, logic [1:0] tgt, logic ld,
                                     logic [1:0] iod, logic [1:0] dws, int len);
        int d;
        int isa = ld ? 2 : 1;
        if (!io) begin
            if (b16) d = 0;
            else if (tgt == 2'd1) d = 1;
            else if (tgt == 2'd2) d = (dws == 2'b00) ? 0 : isa;
            else d = isa;
        end else begin
            if (b16 || tgt == 2'd3) d = 1;
            else if (iod == 2'b00) d = 1;
            else if (iod == 2'b01) d = 2;
            else d = 4;
        end
        if (d >= len) d = len - 1;
        return d;
    endfunction

    function automatic logic [5:0] outs();
        return {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, bios_cs_n, dos_cs_n};
    endfunction

    task automatic check(logic [5:0] act, logic [5:0] exp, string req, int k);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s tick %0d: actual=%b expected=%b", req, k, act, exp);
        end
    endtask

    task automatic run_cycle(logic io, logic wr, logic b16, logic [1:0] tgt, int ws,
                             logic ld, logic [1:0] iod, logic [1:0] dws,
                             logic bd, logic dd, logic stop, logic poke, string req);
        int len = model_len(ws);
        int d = model_dly(io, wr ? b16 : b16, tgt, ld, iod, dws, len);
        @(negedge clk);
        cyc_is_io = io; cyc_is_wr = wr; cyc_16bit = b16; cyc_tgt = tgt;
        ws_count = ws[WS_W-1:0]; cfg_long_dly = ld; cfg_io_dly = iod; cfg_dos_ws = dws;
        cfg_bios_dec = bd; cfg_dos_dec = dd; clk_stopped = stop; cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        cyc_is_io = ~io; cyc_is_wr = ~wr; cyc_16bit = ~b16; cyc_tgt = ~tgt;
        ws_count = '0; cfg_long_dly = ~ld; cfg_io_dly = ~iod; cfg_dos_ws = ~dws;
        cfg_bios_dec = ~bd; cfg_dos_dec = ~dd;
        for (int k = 0; k <= len; k++) begin
            logic cmd = (k >= d) && (k < len);
            logic [5:0] e;
            e[5] = !(cmd && !io && !wr);
            e[4] = !(cmd && !io &&  wr);
            e[3] = !(cmd &&  io && !wr);
            e[2] = !(cmd &&  io &&  wr);
            e[1] = !(!io && tgt == 2'd1 && !stop && k < len && (bd || cmd));
            e[0] = !(!io && tgt == 2'd2 && !stop && k < len && (dd || cmd));
            check(outs(), e, req, k);
            if (poke && k == 1) cyc_start = 1'b1;
            @(negedge clk);
            cyc_start = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        #(CLK_PERIOD * 3);
        @(negedge clk);
        check(outs(), 6'b111111, "R1", 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(outs(), 6'b111111, "R1", 1);

        run_cycle(0, 0, 1, 2'd0, 1, 0, 2'd0, 2'd0, 0, 0, 0, 0, "R3");
        run_cycle(0, 1, 0, 2'd0, 2, 1, 2'd0, 2'd0, 0, 0, 0, 0, "R3");
        run_cycle(0, 0, 0, 2'd0, 2, 0, 2'd0, 2'd0, 0, 0, 0, 0, "R3");
        run_cycle(0, 0, 0, 2'd1, 1, 0, 2'd0, 2'd0, 0, 0, 0, 0, "R8");
        run_cycle(0, 0, 0, 2'd1, 1, 0, 2'd0, 2'd0, 1, 0, 0, 0, "R9");
        run_cycle(0, 1, 0, 2'd2, 1, 1, 2'd0, 2'd0, 0, 0, 0, 0, "R4");
        run_cycle(0, 0, 0, 2'd2, 1, 1, 2'd0, 2'b01, 0, 1, 0, 0, "R4");
        run_cycle(0, 0, 0, 2'd2, 0, 0, 2'd0, 2'b10, 0, 0, 0, 0, "R9");
        run_cycle(1, 0, 0, 2'd3, 1, 0, 2'd3, 2'd0, 0, 0, 0, 0, "R5");
        run_cycle(1, 1, 1, 2'd0, 1, 0, 2'd2, 2'd0, 0, 0, 0, 0, "R5");
        run_cycle(1, 0, 0, 2'd0, 3, 0, 2'b01, 2'd0, 0, 0, 0, 0, "R5");
        run_cycle(1, 1, 0, 2'd0, 3, 0, 2'b11, 2'd0, 0, 0, 0, 0, "R5");
        run_cycle(1, 0, 0, 2'd0, 0, 0, 2'b10, 2'd0, 0, 0, 0, 0, "R6");
        run_cycle(0, 0, 0, 2'd0, 15, 1, 2'd0, 2'd0, 0, 0, 0, 0, "R2");
        run_cycle(0, 0, 0, 2'd1, 1, 0, 2'd0, 2'd0, 1, 1, 1, 0, "R10");
        run_cycle(0, 1, 0, 2'd2, 2, 0, 2'd0, 2'b11, 1, 1, 1, 0, "R10");
        run_cycle(0, 1, 0, 2'd1, 2, 0, 2'd0, 2'd0, 1, 0, 0, 1, "R11");
        run_cycle(1, 0, 0, 2'd0, 1, 0, 2'b01, 2'd0, 0, 0, 0, 1, "R7");

        for (int n = 0; n < 80; n++) begin
            logic [15:0] r = 16'($urandom);
            run_cycle(r[0], r[1], r[2], r[4:3], int'(r[8:5]), r[9], r[11:10],
                      r[13:12], r[14], r[15], ($urandom % 8) == 0,
                      ($urandom % 4) == 0, "R7");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule